// File: doc/BRIEF.md
# Floating-Point Minimum/Maximum Unit

This block is a purely combinational selector. It takes two IEEE-754 binary operands and returns either the smaller or the larger of the two. A format input picks between half (16-bit), single (32-bit) and double (64-bit) elements, and all of them share one 64-bit datapath. One lane per format is built in parallel, and the format input chooses which lane drives the result.

NaN operands never win against a number. When both operands are NaN, the result is the canonical quiet NaN of the selected format. The two zeros are ordered, with negative zero below positive zero. A 5-bit exception vector reports the outcome of the quiet comparison. Only its invalid bit can ever be set, and that happens only when an operand is a signaling NaN.

The unit is used inside a floating-point or vector execution pipeline. The pipeline registers the result and the flags, and it merges the flags into its own status state.

Top module: `fpmm_unit`

## Requirements
- R1: A NaN has an all-ones exponent and a nonzero fraction. When both operands are NaN, the result is the canonical quiet NaN for the selected format: 16'h7E00 for half, 32'h7FC00000 for single, 64'h7FF8000000000000 for double.
- R2: When exactly one operand is NaN, the result is the other operand, for both min and max.
- R3: For min (`is_max_i`=0), when one operand is -0 and the other is +0, the result is -0 in either input order.
- R4: For max (`is_max_i`=1), when one operand is -0 and the other is +0, the result is +0 in either input order.
- R5: In all other cases, min returns A when A is less than B, and returns B otherwise. Max returns B when A is less than B, and returns A otherwise. The comparison is a numeric IEEE less-than.
- R6: `flags_o[4]` (invalid) is 1 exactly when at least one operand is a signaling NaN, meaning a NaN whose top fraction bit is 0. A quiet NaN does not raise the invalid flag.
- R7: `flags_o[3:0]` (divide-by-zero, overflow, underflow, inexact, from bit 3 down to bit 0) are always 0.
- R8: For half and single formats, the result bits above the element width are 0.
- R9: For half and single formats, the operand bits above the element width have no effect on the result or the flags.
- R10: `fmt_i` encodes the format as follows: 0 is half, 1 is single, 2 is double. The value 3 is treated as double.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_a_i | input | 64 | Operand A, right-aligned element |
| op_b_i | input | 64 | Operand B, right-aligned element |
| is_max_i | input | 1 | 0 selects minimum, 1 selects maximum |
| fmt_i | input | 2 | Element format select |
| res_o | output | 64 | Selected element, zero-extended |
| flags_o | output | 5 | Exception flags {NV, DZ, OF, UF, NX} |

## Verification
The unit holds no state, so any internal fault shows on `res_o` or `flags_o` for the same operand pair that exercises it, with no delay.

Some faults change which class an operand falls into. A wrong class decode, such as taking a signaling NaN for a quiet one, or an infinity for a NaN, shows up as a wrong invalid bit or as a NaN passing through to the result. A wrong lane select or a missing zero-extension corrupts the upper result bits for narrow formats. A wrong sign-handling path in the comparator picks the wrong operand whenever the two operands have opposite signs or are both negative.

// File: rtl/fpmm_pkg.sv
package fpmm_pkg;

   typedef enum logic [1:0] {
      FMT_HALF   = 2'd0,
      FMT_SINGLE = 2'd1,
      FMT_DOUBLE = 2'd2,
      FMT_ALIAS  = 2'd3
   } fpmm_fmt_e;

   localparam int unsigned NUM_FMT  = 3;
   localparam int unsigned FLAG_W   = 5;
   localparam int unsigned FLAG_NV  = 4;

   function automatic int unsigned fmt_exp_w(input int unsigned idx);
      case (idx)
         0:       return 5;
         1:       return 8;
         default: return 11;
      endcase
   endfunction

   function automatic int unsigned fmt_man_w(input int unsigned idx);
      case (idx)
         0:       return 10;
         1:       return 23;
         default: return 52;
      endcase
   endfunction

endpackage

// File: rtl/fpmm_classify.sv
module fpmm_classify #(
   parameter int unsigned EXP_W = 8,
   parameter int unsigned MAN_W = 23,
   localparam int unsigned W    = 1 + EXP_W + MAN_W
) (
   input  logic [W-1:0] val_i,
   output logic         sign_o,
   output logic         is_nan_o,
   output logic         is_snan_o,
   output logic         is_zero_o,
   output logic [W-2:0] mag_o
);

   if (EXP_W < 2 || MAN_W < 2) begin : g_param_chk
      $error("fpmm_classify: exponent and fraction need at least 2 bits");
   end

   logic [EXP_W-1:0] expo;
   logic [MAN_W-1:0] frac;
   logic             exp_ones;
   logic             frac_nz;

   assign {sign_o, expo, frac} = val_i;
   assign mag_o     = val_i[W-2:0];
   assign exp_ones  = &expo;
   assign frac_nz   = |frac;
   assign is_nan_o  = exp_ones & frac_nz;
   assign is_snan_o = is_nan_o & ~frac[MAN_W-1];
   assign is_zero_o = ~(|expo) & ~frac_nz;

endmodule

// File: rtl/fpmm_lt_quiet.sv
module fpmm_lt_quiet #(
   parameter int unsigned MAG_W = 31
) (
   input  logic             sign_a_i,
   input  logic             sign_b_i,
   input  logic [MAG_W-1:0] mag_a_i,
   input  logic [MAG_W-1:0] mag_b_i,
   input  logic             any_nan_i,
   input  logic             both_zero_i,
   output logic             lt_o
);

   logic mag_lt;
   logic mag_gt;

   assign mag_lt = mag_a_i < mag_b_i;
   assign mag_gt = mag_b_i < mag_a_i;

   always_comb begin
      if (any_nan_i || both_zero_i) begin
         lt_o = 1'b0;
      end else if (sign_a_i != sign_b_i) begin
         lt_o = sign_a_i;
      end else if (!sign_a_i) begin
         lt_o = mag_lt;
      end else begin
         lt_o = mag_gt;
      end
   end

endmodule

// File: rtl/fpmm_lane.sv
module fpmm_lane #(
   parameter int unsigned EXP_W = 8,
   parameter int unsigned MAN_W = 23,
   localparam int unsigned W    = 1 + EXP_W + MAN_W
) (
   input  logic [W-1:0] a_i,
   input  logic [W-1:0] b_i,
   input  logic         is_max_i,
   output logic [W-1:0] res_o,
   output logic         nv_o
);

   localparam logic [W-1:0] CANON_NAN =
      {1'b0, {EXP_W{1'b1}}, 1'b1, {(MAN_W-1){1'b0}}};

   logic [W-1:0] opnd   [2];
   logic         sgn    [2];
   logic         nan    [2];
   logic         snan   [2];
   logic         zero   [2];
   logic [W-2:0] mag    [2];
   logic         a_lt_b;

   assign opnd[0] = a_i;
   assign opnd[1] = b_i;

   for (genvar k = 0; k < 2; k++) begin : g_cls
      fpmm_classify #(.EXP_W(EXP_W), .MAN_W(MAN_W)) cls_i (
         .val_i     (opnd[k]),
         .sign_o    (sgn[k]),
         .is_nan_o  (nan[k]),
         .is_snan_o (snan[k]),
         .is_zero_o (zero[k]),
         .mag_o     (mag[k])
      );
   end

   fpmm_lt_quiet #(.MAG_W(W-1)) cmp_i (
      .sign_a_i    (sgn[0]),
      .sign_b_i    (sgn[1]),
      .mag_a_i     (mag[0]),
      .mag_b_i     (mag[1]),
      .any_nan_i   (nan[0] | nan[1]),
      .both_zero_i (zero[0] & zero[1]),
      .lt_o        (a_lt_b)
   );

   always_comb begin
      if (nan[0] && nan[1]) begin
         res_o = CANON_NAN;
      end else if (nan[0]) begin
         res_o = b_i;
      end else if (nan[1]) begin
         res_o = a_i;
      end else if (zero[0] && zero[1] && (sgn[0] != sgn[1])) begin
         res_o = (sgn[0] ^ is_max_i) ? a_i : b_i;
      end else if (is_max_i) begin
         res_o = a_lt_b ? b_i : a_i;
      end else begin
         res_o = a_lt_b ? a_i : b_i;
      end
   end

   assign nv_o = snan[0] | snan[1];

   always_comb begin
      if (nan[0] && nan[1]) begin
         AST_TWO_NAN_QUIET: assert (&res_o[W-2:MAN_W] && res_o[MAN_W-1] && !res_o[W-1]); // R1
      end
      if (nan[0] != nan[1]) begin
         AST_ONE_NAN_PASS: assert (res_o == (nan[0] ? b_i : a_i)); // R2
      end
      if (zero[0] && zero[1] && !nan[0] && !nan[1]) begin
         AST_SIGNED_ZERO: assert (res_o[W-2:0] == '0 && res_o[W-1] == (is_max_i ? (sgn[0] & sgn[1]) : (sgn[0] | sgn[1]))); // R3 R4
      end
      if (!nan[0] && !nan[1]) begin
         AST_PICKS_INPUT: assert (res_o == a_i || res_o == b_i); // R5
      end
      if (nv_o) begin
         AST_NV_NEEDS_NAN: assert (nan[0] || nan[1]); // R6
      end
   end

endmodule

// File: rtl/fpmm_unit.sv
module fpmm_unit #(
   parameter int unsigned DATA_W = 64
) (
   input  logic [DATA_W-1:0]              op_a_i,
   input  logic [DATA_W-1:0]              op_b_i,
   input  logic                           is_max_i,
   input  logic [1:0]                     fmt_i,
   output logic [DATA_W-1:0]              res_o,
   output logic [fpmm_pkg::FLAG_W-1:0]    flags_o
);
   import fpmm_pkg::*;

   localparam int unsigned WIDEST = 1 + fmt_exp_w(NUM_FMT-1) + fmt_man_w(NUM_FMT-1);

   if (DATA_W < WIDEST) begin : g_width_chk
      $error("fpmm_unit: DATA_W narrower than the widest element");
   end

   logic [DATA_W-1:0] lane_res [NUM_FMT];
   logic              lane_nv  [NUM_FMT];
   logic [1:0]        lane_sel;

   for (genvar g = 0; g < NUM_FMT; g++) begin : g_lane
      localparam int unsigned EW = fmt_exp_w(g);
      localparam int unsigned MW = fmt_man_w(g);
      localparam int unsigned LW = 1 + EW + MW;
      logic [LW-1:0] lane_out;

      fpmm_lane #(.EXP_W(EW), .MAN_W(MW)) lane_i (
         .a_i      (op_a_i[LW-1:0]),
         .b_i      (op_b_i[LW-1:0]),
         .is_max_i (is_max_i),
         .res_o    (lane_out),
         .nv_o     (lane_nv[g])
      );

      assign lane_res[g] = DATA_W'(lane_out);
   end

   assign lane_sel = (fmt_i == FMT_ALIAS) ? 2'(FMT_DOUBLE) : fmt_i;

   always_comb begin
      res_o   = lane_res[lane_sel];
      flags_o = '0;
      flags_o[FLAG_NV] = lane_nv[lane_sel];
   end

   always_comb begin
      if (fmt_i == FMT_HALF) begin
         AST_HALF_UPPER_ZERO: assert (res_o[DATA_W-1:16] == '0); // R8
      end
      if (fmt_i == FMT_SINGLE) begin
         AST_SINGLE_UPPER_ZERO: assert (res_o[DATA_W-1:32] == '0); // R8
      end
      AST_SPARE_FLAGS_ZERO: assert (flags_o[FLAG_NV-1:0] == '0); // R7
   end

endmodule

// File: tb/fpmm_unit_tb_top.sv
module fpmm_unit_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [63:0] op_a, op_b;
   logic        is_max;
   logic [1:0]  fmt;
   logic [63:0] res;
   logic [4:0]  flags;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 0;

   always #2.5 clk = ~clk;

   fpmm_unit dut_i (
      .op_a_i   (op_a),
      .op_b_i   (op_b),
      .is_max_i (is_max),
      .fmt_i    (fmt),
      .res_o    (res),
      .flags_o  (flags)
   );

   function automatic int ew(input logic [1:0] f);
      return (f == 2'd0) ? 5 : (f == 2'd1) ? 8 : 11;
   endfunction
   function automatic int mw(input logic [1:0] f);
      return (f == 2'd0) ? 10 : (f == 2'd1) ? 23 : 52;
   endfunction
   function automatic logic [63:0] lmask(input int w);
      return (w >= 64) ? '1 : ((64'd1 << w) - 64'd1);
   endfunction

   // Reference model built from R1..R10; returns {nv, result}, tag names the rule applied
   function automatic logic [64:0] ref_calc(input logic [1:0] f, input logic mx,
                                            input logic [63:0] a, input logic [63:0] b,
                                            output string tag);
      int e = ew(f), m = mw(f), w = 1 + ew(f) + mw(f);
      logic [63:0] aa = a & lmask(w), bb = b & lmask(w);
      logic [63:0] emax = lmask(e);
      logic [63:0] magm = lmask(w - 1);
      logic sa = aa[w-1], sb = bb[w-1];
      logic na = ((aa >> m) & emax) == emax && (aa & lmask(m)) != 0;
      logic nb = ((bb >> m) & emax) == emax && (bb & lmask(m)) != 0;
      logic qa = aa[m-1], qb = bb[m-1];
      logic za = (aa & magm) == 0, zb = (bb & magm) == 0;
      logic nv = (na && !qa) || (nb && !qb);
      logic lt;
      logic [63:0] r;
      if (na && nb) begin
         r = (emax << m) | (64'd1 << (m - 1)); tag = "R1";
      end else if (na || nb) begin
         r = na ? bb : aa; tag = "R2";
      end else if (za && zb && sa != sb) begin
         r = mx ? ((sa == 0) ? aa : bb) : ((sa == 1) ? aa : bb);
         tag = mx ? "R4" : "R3";
      end else begin
         if (za && zb) lt = 0;
         else if (sa != sb) lt = sa;
         else if (!sa) lt = (aa & magm) < (bb & magm);
         else lt = (aa & magm) > (bb & magm);
         r = mx ? (lt ? bb : aa) : (lt ? aa : bb);
         tag = "R5";
      end
      if (f == 2'd3) tag = {tag, " R10"};
      else if (f != 2'd2) tag = {tag, " R8 R9"};
      return {nv, r};
   endfunction

   function automatic logic [63:0] build(input logic [1:0] f, input int kind, input logic [63:0] other);
      int e = ew(f), m = mw(f), w = 1 + ew(f) + mw(f);
      logic [63:0] junk = {$urandom, $urandom};
      logic [63:0] v = {$urandom, $urandom} & lmask(w);
      logic [63:0] expf = lmask(e) << m;
      case (kind)
         0: v = (v & ~expf) | expf | (64'd1 << (m - 1));
         1: v = ((v & ~expf) | expf | 64'd1) & ~(64'd1 << (m - 1));
         2: v = v & (64'd1 << (w - 1));
         3: v = (v & (64'd1 << (w - 1))) | expf;
         4: v = (other & lmask(w)) ^ (64'd1 << (w - 1));
         5: v = other & lmask(w);
         default: ;
      endcase
      return (w < 64) ? (v | (junk & ~lmask(w))) : v;
   endfunction

   task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", tag, got, exp);
      end
   endtask

   task automatic apply(input logic [1:0] f, input logic mx, input logic [63:0] a, input logic [63:0] b);
      string tag;
      logic [64:0] e;
      @(negedge clk);
      fmt = f; is_max = mx; op_a = a; op_b = b;
      #1;
      e = ref_calc(f, mx, a, b, tag);
      check({tag, " result"}, res, e[63:0]);
      check("R6 R7 flags", {59'd0, flags}, {59'd0, e[64], 4'b0000});
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual hung expected done");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd2024));
      op_a = '0; op_b = '0; is_max = 0; fmt = 2'd0;
      repeat (3) @(posedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // reset-state style check: zero operands give zero result and no flags (R5 R7)
      check("R5 idle result", res, 64'd0);
      check("R7 idle flags", {59'd0, flags}, 64'd0);

      // R1 canonical NaN per format (qNaN + sNaN also raises NV, R6)
      apply(2'd0, 0, 64'h7C01, 64'hFE00);
      check("R1 half canon", res, 64'h7E00);
      apply(2'd1, 1, 64'h7F800001, 64'hFFC00000);
      check("R1 single canon", res, 64'h7FC00000);
      apply(2'd2, 0, 64'hFFF8000000000001, 64'h7FF0000000000001);
      check("R1 double canon", res, 64'h7FF8000000000000);
      check("R6 snan nv", {63'd0, flags[4]}, 64'd1);
      // R2 single NaN dropped
      apply(2'd1, 1, 64'h7FC00000, 64'hBF800000);
      check("R2 max qnan drop", res, 64'hBF800000);
      check("R6 qnan no nv", {63'd0, flags[4]}, 64'd0);
      // R3 / R4 signed zeros in both orders
      apply(2'd0, 0, 64'h0000, 64'h8000); check("R3 min +0,-0", res, 64'h8000);
      apply(2'd0, 0, 64'h8000, 64'h0000); check("R3 min -0,+0", res, 64'h8000);
      apply(2'd0, 1, 64'h8000, 64'h0000); check("R4 max -0,+0", res, 64'h0000);
      apply(2'd0, 1, 64'h0000, 64'h8000); check("R4 max +0,-0", res, 64'h0000);
      // R5 negative ordering, R9 junk upper bits, R10 alias format
      apply(2'd2, 0, 64'hC000000000000000, 64'hBFF0000000000000);
      check("R5 min negatives", res, 64'hC000000000000000);
      apply(2'd1, 0, 64'hDEADBEEF3F800000, 64'h12345678C0000000);
      check("R9 R8 single junk", res, 64'h00000000C0000000);
      apply(2'd3, 1, 64'h3FF0000000000000, 64'h4000000000000000);
      check("R10 alias double", res, 64'h4000000000000000);

      for (int i = 0; i < 4000; i++) begin
         logic [1:0] f = 2'($urandom_range(0, 3));
         logic [63:0] a = build(f, $urandom_range(0, 9), 64'd0);
         logic [63:0] b = build(f, $urandom_range(0, 9), a);
         apply(f, 1'($urandom_range(0, 1)), a, b);
      end

      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule